// File: doc/BRIEF.md
# BCD Century Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month, a two-digit year and a two-digit century limited to 00–39. A built-in prescaler counts enable pulses from a 32.768 kHz reference. It produces the once-per-second advance and a square-wave phase bit at the frequency-test rate. Month lengths and 29 February are handled automatically. The leap decision is taken directly from the BCD year digits. The day of week runs as its own modulo-7 count beside the date.

A host-side write sequence ends by pulsing a load strobe with a full 64-bit time word. All fields are replaced at once, and the sub-second prescaler restarts, so the next advance comes exactly one second later. The current time is always visible as a registered 64-bit snapshot. A halt input models a stopped oscillator. While it is high, nothing advances and the phase bit is frozen.

Byte layout of both the load word and the snapshot, least significant byte first: byte 0 seconds, byte 1 minutes, byte 2 hours, byte 3 day of week, byte 4 date, byte 5 month, byte 6 year, byte 7 century.

Top module: `bcd_calendar_core`

## Requirements
- R1: A synchronous active-low reset sets the snapshot to century 00, year 00, month 01, date 01, day 01 and time 00:00:00 (64'h00_00_01_01_01_00_00_00 in the byte layout above), with the phase bit at 0.
- R2: A load strobe replaces every field with the load word on the next clock edge, wins over a seconds advance on that same edge, and clears the prescaler, so the next advance comes REF_HZ counted reference ticks after the load.
- R3: Seconds advance once for every REF_HZ clock cycles in which the reference tick is high; cycles with the tick low do not count, and the snapshot does not change between advances.
- R4: Seconds and minutes count 00–59 and hours 00–23 in packed BCD, each carrying into the next field on wrap; an hour wrap advances the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 or 29 in month 02; a date wrap advances the month, and a month wrap from 12 to 01 advances the year.
- R6: The year is leap when its BCD value is a multiple of 4: tens digit even with units 0, 4 or 8, or tens digit odd with units 2 or 6; year 00 counts as leap.
- R7: A year wrap from 99 to 00 advances the century, and the century wraps from 39 to 00.
- R8: The day of week advances by one on every date advance, wrapping from 07 to 01, independent of date and month.
- R9: While halt is high, the snapshot, the prescaler and the phase bit hold their values; counting resumes from the held prescaler value when halt falls.
- R10: The phase bit is 0 for the first REF_HZ/(2*PHASE_HZ) counted ticks of each second, then 1 for the next, repeating, so it is a square wave at PHASE_HZ.
- R11: A field holding a non-BCD digit or a value at or above its maximum rolls to its minimum (00, or 01 for day, date and month) on its next advance and carries onward, instead of locking up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per reference oscillator period |
| halt | input | 1 | High stops the prescaler and the calendar |
| ld_stb | input | 1 | One-cycle strobe that loads ld_data into all fields |
| ld_data | input | 64 | Time word to load, byte layout as above |
| snap_time | output | 64 | Current time word, byte layout as above |
| freq_phase | output | 1 | Square wave at PHASE_HZ for frequency test |

## Verification
The bench builds the block with REF_HZ = 32 and PHASE_HZ = 4, so one second takes 32 clock cycles with the reference tick held high, and the phase bit changes every 4 counted ticks. At that scale every rollover can be reached by loading a value one second before the boundary and waiting one second: year ends, century wraps, every month length, leap and non-leap Februaries, and invalid digits. The short second also makes it cheap to check the cycle just before each advance, halted spans, gated reference ticks, and a load that lands on the advancing edge.

// File: rtl/cal_pkg.sv
// Package: shared constants and pure functions for the BCD calendar.
// Assumes packed BCD bytes; field index i occupies byte i of a time word.
package cal_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 8;
    localparam int TIME_W     = FIELD_W * NUM_FIELDS;

    // Field indices: also the byte position inside a time word.
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;
    localparam int F_CENT  = 7;

    // Reset value: century 00, year 00, 01/01, day 01, 00:00:00.
    localparam logic [TIME_W-1:0] RST_TIME = 64'h00_00_01_01_01_00_00_00;

    // Leap test on the BCD year digits: multiple of four.
    function automatic logic year_is_leap(input logic [FIELD_W-1:0] yr);
        logic [3:0] units;
        units = yr[3:0];
        if (yr[4]) begin
            return (units == 4'd2) || (units == 4'd6);
        end
        return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    endfunction

    // Last valid date of a BCD month; unknown months get 31.
    function automatic logic [FIELD_W-1:0] month_last_date(input logic [FIELD_W-1:0] mon,
                                                           input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Lowest legal value of a field.
    function automatic logic [FIELD_W-1:0] field_lo(input int idx);
        case (idx)
            F_DOW, F_DATE, F_MONTH: return 8'h01;
            default:                return 8'h00;
        endcase
    endfunction

    // Highest legal value of a field (date is replaced by the month limit).
    function automatic logic [FIELD_W-1:0] field_hi(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DOW:        return 8'h07;
            F_DATE:       return 8'h31;
            F_MONTH:      return 8'h12;
            F_YEAR:       return 8'h99;
            default:      return 8'h39;
        endcase
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
// Module: cal_prescaler
// Divides counted reference ticks into a one-cycle seconds advance and a
// square-wave phase bit. Assumes REF_HZ and REF_HZ/(2*PHASE_HZ) are powers
// of two so the phase is a plain counter bit. clear restarts the second.
module cal_prescaler #(
    parameter int REF_HZ   = 32768,
    parameter int PHASE_HZ = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic run,
    input  logic clear,
    output logic sec_tick,
    output logic phase
);
    localparam int CNT_W      = $clog2(REF_HZ);
    localparam int PHASE_HALF = REF_HZ / (2 * PHASE_HZ);
    localparam int PH_BIT     = $clog2(PHASE_HALF);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_HZ - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             count_en;

    // Purpose: a reference tick counts only while the oscillator runs.
    assign count_en = run && ref_tick;

    // Purpose: sub-second position, cleared by reset or a load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Purpose: one-cycle advance on the last counted tick of a second.
    assign sec_tick = count_en && !clear && (cnt_q == LAST);
    assign phase    = cnt_q[PH_BIT];
endmodule

// File: rtl/cal_bcd_step.sv
// Module: cal_bcd_step
// Combinational next value of one packed-BCD field. A value with a non-BCD
// digit or at/above hi wraps to lo and raises wrap; otherwise it counts up
// by one in BCD. Assumes lo and hi are valid BCD.
module cal_bcd_step
    import cal_pkg::*;
(
    input  logic [FIELD_W-1:0] cur,
    input  logic [FIELD_W-1:0] lo,
    input  logic [FIELD_W-1:0] hi,
    output logic [FIELD_W-1:0] nxt,
    output logic               wrap
);
    logic bad_digit;

    // Purpose: decide wrap and form the incremented BCD value.
    always_comb begin
        bad_digit = (cur[3:0] > 4'd9) || (cur[7:4] > 4'd9);
        wrap      = bad_digit || (cur >= hi);
        if (wrap) begin
            nxt = lo;
        end else if (cur[3:0] == 4'd9) begin
            nxt = {cur[7:4] + 4'd1, 4'd0};
        end else begin
            nxt = {cur[7:4], cur[3:0] + 4'd1};
        end
    end
endmodule

// File: rtl/cal_month_limit.sv
// Module: cal_month_limit
// Last valid date for the current month and year, with the leap rule
// taken from the BCD year digits. Purely combinational.
module cal_month_limit
    import cal_pkg::*;
(
    input  logic [FIELD_W-1:0] month,
    input  logic [FIELD_W-1:0] year,
    output logic [FIELD_W-1:0] last_date
);
    logic leap;

    // Purpose: leap flag, then month length.
    always_comb begin
        leap      = year_is_leap(year);
        last_date = month_last_date(month, leap);
    end
endmodule

// File: rtl/cal_time_chain.sv
// Module: cal_time_chain
// Field registers and carry chain: sec -> min -> hour -> date -> month ->
// year -> century, with day of week stepping beside the date. A load
// replaces every field and wins over step. Assumes step is one cycle wide.
module cal_time_chain
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] cur_time
);
    logic [FIELD_W-1:0] fld_v  [NUM_FIELDS];
    logic [FIELD_W-1:0] nxt_v  [NUM_FIELDS];
    logic               wrap_v [NUM_FIELDS];
    logic               inc_v  [NUM_FIELDS];
    logic [FIELD_W-1:0] date_hi;
    logic               unused_wraps;

    // Purpose: month length for the date field's upper limit.
    cal_month_limit u_mlim (
        .month     (fld_v[F_MONTH]),
        .year      (fld_v[F_YEAR]),
        .last_date (date_hi)
    );

    // Purpose: ripple carry enables; day of week rides on the date enable.
    assign inc_v[F_SEC]   = step;
    assign inc_v[F_MIN]   = inc_v[F_SEC]   && wrap_v[F_SEC];
    assign inc_v[F_HOUR]  = inc_v[F_MIN]   && wrap_v[F_MIN];
    assign inc_v[F_DATE]  = inc_v[F_HOUR]  && wrap_v[F_HOUR];
    assign inc_v[F_DOW]   = inc_v[F_DATE];
    assign inc_v[F_MONTH] = inc_v[F_DATE]  && wrap_v[F_DATE];
    assign inc_v[F_YEAR]  = inc_v[F_MONTH] && wrap_v[F_MONTH];
    assign inc_v[F_CENT]  = inc_v[F_YEAR]  && wrap_v[F_YEAR];
    assign unused_wraps   = wrap_v[F_CENT] ^ wrap_v[F_DOW];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        logic [FIELD_W-1:0] fld_q;
        logic [FIELD_W-1:0] hi_sel;

        if (i == F_DATE) begin : g_dyn
            assign hi_sel = date_hi;
        end else begin : g_fix
            assign hi_sel = field_hi(i);
        end

        // Purpose: next value and wrap of this field.
        cal_bcd_step u_step (
            .cur  (fld_q),
            .lo   (field_lo(i)),
            .hi   (hi_sel),
            .nxt  (nxt_v[i]),
            .wrap (wrap_v[i])
        );

        // Purpose: field register with reset, load and advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q <= RST_TIME[i*FIELD_W +: FIELD_W];
            end else if (load) begin
                fld_q <= load_val[i*FIELD_W +: FIELD_W];
            end else if (inc_v[i]) begin
                fld_q <= nxt_v[i];
            end
        end

        assign fld_v[i]                       = fld_q;
        assign cur_time[i*FIELD_W +: FIELD_W] = fld_q;
    end
endmodule

// File: rtl/bcd_calendar_core.sv
// Module: bcd_calendar_core (top)
// BCD calendar with century, driven by a reference-tick prescaler.
// Assumes ref_tick and ld_stb are synchronous to clk; halt freezes all
// counting; a load restarts the current second.
module bcd_calendar_core
    import cal_pkg::*;
#(
    parameter int REF_HZ   = 32768,
    parameter int PHASE_HZ = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              halt,
    input  logic              ld_stb,
    input  logic [TIME_W-1:0] ld_data,
    output logic [TIME_W-1:0] snap_time,
    output logic              freq_phase
);
    logic sec_tick;

    // Purpose: seconds advance and frequency-test phase.
    cal_prescaler #(
        .REF_HZ   (REF_HZ),
        .PHASE_HZ (PHASE_HZ)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .run      (!halt),
        .clear    (ld_stb),
        .sec_tick (sec_tick),
        .phase    (freq_phase)
    );

    // Purpose: calendar registers and carry chain.
    cal_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_tick),
        .load     (ld_stb),
        .load_val (ld_data),
        .cur_time (snap_time)
    );
endmodule

// File: rtl/bcd_calendar_core_chk.sv
// Module: bcd_calendar_core_chk
// Property checker bound into bcd_calendar_core.
module bcd_calendar_core_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              ld_stb,
    input logic [TIME_W-1:0] ld_data,
    input logic [TIME_W-1:0] snap_time,
    input logic              freq_phase,
    input logic              sec_tick
);
    // R1: reset leaves the fixed start time.
    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (snap_time == RST_TIME && !freq_phase));

    // R2: the load word appears on the next edge.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (snap_time == $past(ld_data)));

    // R10: a load restarts the second with the phase low.
    p_phase_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> !freq_phase);

    // R3: without advance or load the time holds.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_stb && !sec_tick) |=> $stable(snap_time));

    // R4: after an advance the seconds byte is valid BCD within 00-59.
    p_sec_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !ld_stb) |=> (snap_time[3:0] <= 4'd9 && snap_time[7:0] <= 8'h59));

    // R9: halt blocks advances and freezes the phase.
    p_halt_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !sec_tick);

    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ld_stb) |=> ($stable(snap_time) && $stable(freq_phase)));
endmodule

bind bcd_calendar_core bcd_calendar_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .ld_stb     (ld_stb),
    .ld_data    (ld_data),
    .snap_time  (snap_time),
    .freq_phase (freq_phase),
    .sec_tick   (sec_tick)
);

// File: tb/bcd_calendar_core_tb.sv
module bcd_calendar_core_tb;
    localparam int REF_HZ  = 32;
    localparam int PHASE_HZ = 4;
    localparam int SEC_CYC = REF_HZ;
    localparam int NV      = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        halt = 1'b0;
    logic        ld_stb = 1'b0;
    logic [63:0] ld_data = '0;
    logic [63:0] snap_time;
    logic        freq_phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar_core #(.REF_HZ(REF_HZ), .PHASE_HZ(PHASE_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .halt(halt),
        .ld_stb(ld_stb), .ld_data(ld_data),
        .snap_time(snap_time), .freq_phase(freq_phase)
    );

    // {start, expected after one second}; layout CC_YY_MM_DD_WW_HH_mm_ss.
    localparam logic [127:0] VEC [NV] = '{
        {64'h20_24_03_15_03_10_20_09, 64'h20_24_03_15_03_10_20_10}, // R4 digit carry
        {64'h20_24_03_15_03_10_20_59, 64'h20_24_03_15_03_10_21_00}, // R4
        {64'h20_24_03_15_03_10_59_59, 64'h20_24_03_15_03_11_00_00}, // R4
        {64'h20_24_03_15_03_23_59_59, 64'h20_24_03_16_04_00_00_00}, // R4
        {64'h20_24_03_15_07_23_59_59, 64'h20_24_03_16_01_00_00_00}, // R8 dow 7->1
        {64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00}, // R5 feb plain
        {64'h20_24_02_28_02_23_59_59, 64'h20_24_02_29_03_00_00_00}, // R6 year 24
        {64'h20_24_02_29_03_23_59_59, 64'h20_24_03_01_04_00_00_00}, // R5
        {64'h20_24_04_30_05_23_59_59, 64'h20_24_05_01_06_00_00_00}, // R5 30-day
        {64'h20_24_11_30_06_23_59_59, 64'h20_24_12_01_07_00_00_00}, // R5
        {64'h20_24_07_30_02_23_59_59, 64'h20_24_07_31_03_00_00_00}, // R5 31-day
        {64'h20_24_08_31_06_23_59_59, 64'h20_24_09_01_07_00_00_00}, // R5
        {64'h20_24_12_31_02_23_59_59, 64'h20_25_01_01_03_00_00_00}, // R5 year end
        {64'h20_99_12_31_05_23_59_59, 64'h21_00_01_01_06_00_00_00}, // R7 century up
        {64'h39_99_12_31_05_23_59_59, 64'h00_00_01_01_06_00_00_00}, // R7 39->00
        {64'h21_00_02_28_01_23_59_59, 64'h21_00_02_29_02_00_00_00}, // R6 year 00
        {64'h20_12_02_28_01_23_59_59, 64'h20_12_02_29_02_00_00_00}, // R6 year 12
        {64'h20_10_02_28_01_23_59_59, 64'h20_10_03_01_02_00_00_00}, // R6 year 10
        {64'h20_96_02_28_01_23_59_59, 64'h20_96_02_29_02_00_00_00}, // R6 year 96
        {64'h20_30_02_28_01_23_59_59, 64'h20_30_03_01_02_00_00_00}, // R6 year 30
        {64'h20_24_03_15_03_10_20_5A, 64'h20_24_03_15_03_10_21_00}, // R11 bad sec
        {64'h20_24_03_15_03_10_7B_59, 64'h20_24_03_15_03_11_00_00}, // R11 bad min
        {64'h20_24_03_15_03_25_59_59, 64'h20_24_03_16_04_00_00_00}, // R11 hour 25
        {64'h20_24_13_31_02_23_59_59, 64'h20_25_01_01_03_00_00_00}, // R11 month 13
        {64'h20_24_04_32_01_23_59_59, 64'h20_24_05_01_02_00_00_00}, // R11 date 32
        {64'h20_24_03_15_00_23_59_59, 64'h20_24_03_16_01_00_00_00}, // R8 dow 0
        {64'h20_24_03_15_09_23_59_59, 64'h20_24_03_16_01_00_00_00}  // R11 dow 9
    };
    localparam int VREQ [NV] = '{4,4,4,4,8,5,6,5,5,5,5,5,5,7,7,6,6,6,6,6,11,11,11,11,11,8,11};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive a load strobe for one edge; returns just after the next negedge.
    task automatic load(input logic [63:0] v);
        ld_stb  = 1'b1;
        ld_data = v;
        @(negedge clk);
        ld_stb  = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset time", snap_time, 64'h00_00_01_01_01_00_00_00);
        chk("R1 reset phase", {63'd0, freq_phase}, 64'd0);

        // Table walk: each vector is one second after a load.
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][127:64]);
            repeat (SEC_CYC - 1) @(negedge clk);
            chk($sformatf("R3 hold before advance, vector %0d", i), snap_time, VEC[i][127:64]);
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VREQ[i], i), snap_time, VEC[i][63:0]);
        end

        // R4: two seconds across a year end.
        load(64'h20_24_12_31_02_23_59_58);
        repeat (2 * SEC_CYC) @(negedge clk);
        chk("R4 two seconds", snap_time, 64'h20_25_01_01_03_00_00_00);

        // R2: reload mid-second restarts the second.
        load(64'h20_24_03_15_03_08_00_00);
        repeat (20) @(negedge clk);
        load(64'h20_24_03_15_03_09_00_30);
        repeat (SEC_CYC - 1) @(negedge clk);
        chk("R2 restart hold", snap_time, 64'h20_24_03_15_03_09_00_30);
        @(negedge clk);
        chk("R2 restart advance", snap_time, 64'h20_24_03_15_03_09_00_31);

        // R2: load on the advancing edge wins.
        load(64'h20_24_03_15_03_10_20_00);
        repeat (SEC_CYC - 1) @(negedge clk);
        load(64'h20_24_03_15_03_12_00_00);
        chk("R2 load beats advance", snap_time, 64'h20_24_03_15_03_12_00_00);
        repeat (SEC_CYC - 1) @(negedge clk);
        chk("R2 hold after priority load", snap_time, 64'h20_24_03_15_03_12_00_00);
        @(negedge clk);
        chk("R2 advance after priority load", snap_time, 64'h20_24_03_15_03_12_00_01);

        // R3: cycles without a reference tick do not count.
        load(64'h20_24_03_15_03_07_00_00);
        ref_tick = 1'b0;
        repeat (50) @(negedge clk);
        chk("R3 no ticks", snap_time, 64'h20_24_03_15_03_07_00_00);
        ref_tick = 1'b1;
        repeat (SEC_CYC - 1) @(negedge clk);
        chk("R3 ticks resumed hold", snap_time, 64'h20_24_03_15_03_07_00_00);
        @(negedge clk);
        chk("R3 ticks resumed advance", snap_time, 64'h20_24_03_15_03_07_00_01);

        // R10: phase low for 4 counted ticks, then high for 4.
        load(64'h20_24_03_15_03_06_00_00);
        repeat (3) @(negedge clk);
        chk("R10 phase at 3", {63'd0, freq_phase}, 64'd0);
        @(negedge clk);
        chk("R10 phase at 4", {63'd0, freq_phase}, 64'd1);
        repeat (3) @(negedge clk);
        chk("R10 phase at 7", {63'd0, freq_phase}, 64'd1);
        @(negedge clk);
        chk("R10 phase at 8", {63'd0, freq_phase}, 64'd0);

        // R9: halt freezes time, prescaler and phase.
        load(64'h20_24_03_15_03_10_20_40);
        repeat (13) @(negedge clk);
        chk("R10 phase at 13", {63'd0, freq_phase}, 64'd1);
        halt = 1'b1;
        repeat (40) @(negedge clk);
        chk("R9 halted time", snap_time, 64'h20_24_03_15_03_10_20_40);
        chk("R9 halted phase", {63'd0, freq_phase}, 64'd1);
        halt = 1'b0;
        repeat (SEC_CYC - 14) @(negedge clk);
        chk("R9 resume hold", snap_time, 64'h20_24_03_15_03_10_20_40);
        @(negedge clk);
        chk("R9 resume advance", snap_time, 64'h20_24_03_15_03_10_20_41);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule